// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block is the digital controller that sits in front of a successive-approximation converter. A programmable prescaler derives a conversion clock from the master clock. After reset the block waits a programmable warm-up time. It then accepts start requests. A start can come from a software pulse, or from the rising edge of one of several hardware trigger inputs. Once a start is accepted, the block holds the sample for a programmable number of conversion-clock periods. It then asks the analog converter for a result over a request/done handshake.

A finished conversion is stored in a result register and raises a data-ready flag. That flag is the request line for a DMA engine. Reading the result clears the flag. If a new result lands on top of an unread one, the block raises an overrun flag. A software reset command puts every piece of control state back to its power-on value.

All timing comes from three small fields of a single 32-bit mode word. The field positions are fixed, so software laid out for this word keeps working.

Top module: `adc_conv_seq`

## Requirements
- R1: Only three fields of `mode_word` have any effect: prescaler PRE = bits 13:8, warm-up count SU = bits 20:16, hold count SH = bits 27:24. Every other bit is ignored.
- R2: The conversion-clock period is 2*(PRE+1) master cycles. `ana_req` rises exactly (SH+1)*2*(PRE+1) master cycles after the clock edge that accepts a software start.
- R3: After `rst_n` is released, starts are ignored during a warm-up of (SU+1)*8 conversion periods, counted from the last reset edge. A start sampled exactly at the end of that count is ignored. A start sampled one cycle later is accepted.
- R4: With `hw_trig_en` low, a one-cycle `sw_start` pulse begins a conversion, and the trigger inputs have no effect.
- R5: With `hw_trig_en` high, `sw_start` is ignored, and so is every trigger input other than `trig_in[trig_sel]`. A rising edge of the selected input starts exactly one conversion, however long the input then stays high. This start comes 2 cycles later than a software start, because of the two-flop synchroniser.
- R6: A start request that arrives while a sample or conversion is in progress is ignored. It is not queued.
- R7: `ana_req` stays high until `ana_done` is seen. On that edge, `ana_data` is stored in `result` and `data_ready` goes high. `ana_req` is low in the following cycle.
- R8: A one-cycle `result_rd` pulse clears `data_ready` and `overrun` and leaves `result` unchanged. If a read and a completion happen in the same cycle, `data_ready` stays high and `overrun` is cleared.
- R9: A completion while `data_ready` is high, with no read in that cycle, sets `overrun` and replaces `result` with the newer value.
- R10: A `sw_reset` pulse does the following: clears `result`, `data_ready` and `overrun`; aborts any conversion in progress (`ana_req` low in the next cycle); and restarts the warm-up.
- R11: While `rst_n` is low, `result` is 0 and `data_ready`, `overrun` and `ana_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 32 | Timing fields: prescaler, warm-up count, hold count |
| hw_trig_en | input | 1 | 1 = start on the selected trigger edge, 0 = start from software |
| trig_sel | input | SEL_W (1) | Index of the hardware trigger input to use |
| trig_in | input | NUM_TRIG (2) | Asynchronous hardware trigger inputs (external pin, timer output) |
| sw_start | input | 1 | One-cycle software start request |
| sw_reset | input | 1 | One-cycle command that restores all control state to its defaults |
| ana_req | output | 1 | Conversion request to the analog converter |
| ana_done | input | 1 | One-cycle completion strobe from the converter |
| ana_data | input | DATA_W (10) | Converter result, valid with `ana_done` |
| result_rd | input | 1 | One-cycle read strobe for the result register |
| result | output | DATA_W (10) | Last completed conversion result |
| data_ready | output | 1 | Unread result present; used as the DMA request |
| overrun | output | 1 | An unread result was overwritten |

## Verification
The timing path is exercised in two ways. Start-to-request latency is measured for several prescaler and hold settings, including the smallest values and a word with all unused bits set; this separates a wrong divider formula, a wrong hold formula and a wrong field position. The warm-up boundary is probed one cycle on each side of its end, which exposes an off-by-one in the warm-up count. Start sources are swapped between software, the selected trigger and the unselected trigger, and trigger levels are held high, so that missing edge detection or a wrong mux shows up as an extra or missing conversion. Finally, completions are issued with and without intervening reads and with a software reset in mid-conversion, which separates the clearing, overwrite and abort paths.

// File: rtl/adc_seq_pkg.sv
// Shared constants and types for the conversion sequencer.
// Field positions of the mode word are fixed; widths derive from them.
package adc_seq_pkg;

    localparam int MODE_W    = 32;
    localparam int PRE_LSB   = 8;
    localparam int PRE_W     = 6;
    localparam int SU_LSB    = 16;
    localparam int SU_W      = 5;
    localparam int SH_LSB    = 24;
    localparam int SH_W      = 4;
    localparam int WARM_MULT = 8;

    localparam logic [MODE_W-1:0] MODE_MASK =
        ((((MODE_W)'(1) << PRE_W) - 1) << PRE_LSB) |
        ((((MODE_W)'(1) << SU_W)  - 1) << SU_LSB)  |
        ((((MODE_W)'(1) << SH_W)  - 1) << SH_LSB);

    typedef enum logic [1:0] {
        SEQ_WARM   = 2'd0,
        SEQ_IDLE   = 2'd1,
        SEQ_SAMPLE = 2'd2,
        SEQ_CONV   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [SH_W-1:0]  hold;
        logic [SU_W-1:0]  warm;
        logic [PRE_W-1:0] pre;
    } mode_fields_t;

    // Pull the three timing fields out of the mode word.
    function automatic mode_fields_t split_mode(input logic [MODE_W-1:0] w);
        mode_fields_t f;
        f.pre  = w[PRE_LSB +: PRE_W];
        f.warm = w[SU_LSB  +: SU_W];
        f.hold = w[SH_LSB  +: SH_W];
        return f;
    endfunction

endpackage

// File: rtl/adc_tick_div.sv
// Conversion-clock generator.
// Emits a one-cycle tick every 2*(pre+1) master cycles.
// Assumes: clr restarts the count, so the first tick after clr comes
// exactly 2*(pre+1) cycles later. If pre shrinks mid-count, the counter
// wraps instead of hanging.
module adc_tick_div #(
    parameter int PRE_BITS = 6,
    localparam int CNT_W   = PRE_BITS + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [PRE_BITS-1:0] prescal,
    output logic                tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = {prescal, 1'b1};
    assign tick = (cnt == lim);

    // Count master cycles within one conversion-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt >= lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_trig_detect.sv
// Hardware trigger front end.
// Each input passes through two synchroniser flops and one history flop,
// and a rising edge gives a one-cycle pulse. The edge of the source
// picked by sel is forwarded; an out-of-range sel forwards nothing.
// Assumes: trigger inputs are asynchronous and stay stable for at least
// two master cycles.
module adc_trig_detect #(
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic [SEL_W-1:0]   sel,
    output logic               rise
);

    logic [NUM_SRC-1:0] rise_vec;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [2:0] pipe;

        // Synchronise one trigger input and keep one cycle of history.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pipe <= '0;
            end else begin
                pipe <= {pipe[1:0], trig_in[g]};
            end
        end

        assign rise_vec[g] = pipe[1] & ~pipe[2];
    end

    // Forward the edge of the selected source only.
    always_comb begin
        rise = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == SEL_W'(i)) begin
                rise = rise_vec[i];
            end
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Conversion sequencer state machine.
// WARM waits (warm+1)*8 ticks, IDLE waits for a start, SAMPLE holds for
// (hold+1) ticks, and CONV raises the request until the converter answers.
// Assumes: tick comes from a divider that restarts on div_clr. Every
// state change asserts div_clr, so each timed phase begins on a fresh
// conversion-clock period.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SU_BITS = 5,
    parameter int SH_BITS = 4,
    localparam int PH_W   = SU_BITS + $clog2(WARM_MULT) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               tick,
    input  logic [SU_BITS-1:0] warm_cnt,
    input  logic [SH_BITS-1:0] hold_cnt,
    input  logic               start_req,
    input  logic               ana_done,
    output logic               div_clr,
    output logic               ana_req,
    output logic               conv_done
);

    seq_state_t      state;
    seq_state_t      nxt;
    logic [PH_W-1:0] ph_cnt;
    logic [PH_W-1:0] warm_ticks;
    logic [PH_W-1:0] hold_ticks;
    logic            warm_last;
    logic            hold_last;

    assign warm_ticks = (PH_W'(warm_cnt) + 1'b1) * PH_W'(WARM_MULT);
    assign hold_ticks = PH_W'(hold_cnt) + 1'b1;
    assign warm_last  = tick && (ph_cnt >= warm_ticks - 1'b1);
    assign hold_last  = tick && (ph_cnt >= hold_ticks - 1'b1);

    // Choose the next phase from the current one and its exit condition.
    always_comb begin
        nxt = state;
        case (state)
            SEQ_WARM:   if (warm_last) nxt = SEQ_IDLE;
            SEQ_IDLE:   if (start_req) nxt = SEQ_SAMPLE;
            SEQ_SAMPLE: if (hold_last) nxt = SEQ_CONV;
            SEQ_CONV:   if (ana_done)  nxt = SEQ_IDLE;
            default:    nxt = SEQ_WARM;
        endcase
    end

    // Hold the phase; either reset sends it back to warm-up.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= SEQ_WARM;
        end else begin
            state <= nxt;
        end
    end

    // Count conversion-clock ticks spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || (nxt != state)) begin
            ph_cnt <= '0;
        end else if (tick) begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    assign div_clr   = soft_rst || (nxt != state);
    assign ana_req   = (state == SEQ_CONV);
    assign conv_done = (state == SEQ_CONV) && ana_done && !soft_rst;

endmodule

// File: rtl/adc_result_reg.sv
// Result register with data-ready and overrun flags.
// A completion stores the data and raises data_ready; a read clears both
// flags; a completion on top of unread data raises overrun.
// Assumes: conv_done and rd are single-cycle strobes.
module adc_result_reg #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd,
    output logic [DATA_W-1:0] result,
    output logic              data_ready,
    output logic              overrun
);

    // Capture the converter output on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            result <= '0;
        end else if (conv_done) begin
            result <= conv_data;
        end
    end

    // Track unread data and lost results.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            data_ready <= 1'b0;
            overrun    <= 1'b0;
        end else if (conv_done) begin
            data_ready <= 1'b1;
            overrun    <= (overrun | data_ready) & ~rd;
        end else if (rd) begin
            data_ready <= 1'b0;
            overrun    <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Top level of the triggered conversion sequencer.
// Splits the mode word, picks the start source, and connects the
// divider, trigger front end, state machine and result register.
// Assumes: mode_word only changes while no warm-up or sample phase is
// running; sw_start, sw_reset and result_rd are single-cycle pulses.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int NUM_TRIG = 2,
    localparam int SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode_word,
    input  logic                hw_trig_en,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic                sw_start,
    input  logic                sw_reset,
    output logic                ana_req,
    input  logic                ana_done,
    input  logic [DATA_W-1:0]   ana_data,
    input  logic                result_rd,
    output logic [DATA_W-1:0]   result,
    output logic                data_ready,
    output logic                overrun
);

    mode_fields_t fields;
    logic         mode_unused;
    logic         tick;
    logic         div_clr;
    logic         trig_rise;
    logic         start_req;
    logic         conv_done;

    assign fields      = split_mode(mode_word);
    assign mode_unused = ^(mode_word & ~MODE_MASK);
    assign start_req   = hw_trig_en ? trig_rise : sw_start;

    adc_tick_div #(
        .PRE_BITS (PRE_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (div_clr),
        .prescal (fields.pre),
        .tick    (tick)
    );

    adc_trig_detect #(
        .NUM_SRC (NUM_TRIG),
        .SEL_W   (SEL_W)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sw_reset),
        .trig_in (trig_in),
        .sel     (trig_sel),
        .rise    (trig_rise)
    );

    adc_seq_fsm #(
        .SU_BITS (SU_W),
        .SH_BITS (SH_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (sw_reset),
        .tick      (tick),
        .warm_cnt  (fields.warm),
        .hold_cnt  (fields.hold),
        .start_req (start_req),
        .ana_done  (ana_done),
        .div_clr   (div_clr),
        .ana_req   (ana_req),
        .conv_done (conv_done)
    );

    adc_result_reg #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (sw_reset),
        .conv_done  (conv_done),
        .conv_data  (ana_data),
        .rd         (result_rd),
        .result     (result),
        .data_ready (data_ready),
        .overrun    (overrun)
    );

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Protocol checker for the conversion sequencer, attached with bind.
// Looks only at top-level ports.
module adc_conv_seq_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              ana_req,
    input logic              ana_done,
    input logic              result_rd,
    input logic [DATA_W-1:0] result,
    input logic              data_ready,
    input logic              overrun
);

    AST_READY_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(ana_req && ana_done)); // R7

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ana_req) |-> $past(ana_done || sw_reset)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ana_req && ana_done) && !sw_reset) |=> $stable(result)); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (result_rd && !(ana_req && ana_done)) |=> (!data_ready && !overrun)); // R8

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(data_ready && ana_req && ana_done && !result_rd)); // R9

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!data_ready && !overrun && !ana_req && (result == '0))); // R10

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_reset   (sw_reset),
    .ana_req    (ana_req),
    .ana_done   (ana_done),
    .result_rd  (result_rd),
    .result     (result),
    .data_ready (data_ready),
    .overrun    (overrun)
);

// File: tb/adc_conv_seq_bench.sv
// Directed bench for adc_conv_seq, with a behavioural converter model.
module adc_conv_seq_bench;

    localparam int DW  = 10;
    localparam int LAT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   mode_word = '0;
    logic          hw_trig_en = 1'b0;
    logic [0:0]    trig_sel = '0;
    logic [1:0]    trig_in = '0;
    logic          sw_start = 1'b0;
    logic          sw_reset = 1'b0;
    logic          ana_req;
    logic          ana_done = 1'b0;
    logic [DW-1:0] ana_data = '0;
    logic          result_rd = 1'b0;
    logic [DW-1:0] result;
    logic          data_ready;
    logic          overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int req_rises = 0;
    logic req_q = 1'b0;
    int model_val = 100;
    int sent_val = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_conv_seq u_adc_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_word  (mode_word),
        .hw_trig_en (hw_trig_en),
        .trig_sel   (trig_sel),
        .trig_in    (trig_in),
        .sw_start   (sw_start),
        .sw_reset   (sw_reset),
        .ana_req    (ana_req),
        .ana_done   (ana_done),
        .ana_data   (ana_data),
        .result_rd  (result_rd),
        .result     (result),
        .data_ready (data_ready),
        .overrun    (overrun)
    );

    // Cycle counter and request-rise counter.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        req_q <= ana_req;
        if (ana_req && !req_q) req_rises <= req_rises + 1;
    end

    // Converter model: answers LAT cycles after the request rises.
    initial begin
        int mcnt;
        mcnt = 0;
        forever begin
            @(negedge clk);
            if (ana_done) begin
                ana_done = 1'b0;
                mcnt = 0;
            end else if (ana_req) begin
                mcnt++;
                if (mcnt == LAT) begin
                    ana_data = DW'(model_val);
                    sent_val = model_val % 1024;
                    model_val = (model_val + 37) % 1024;
                    ana_done = 1'b1;
                end
            end else begin
                mcnt = 0;
            end
        end
    end

    function automatic logic [31:0] mk_mode(int p, int s, int h);
        return (32'(h) << 24) | (32'(s) << 16) | (32'(p) << 8);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(logic [31:0] m);
        mode_word = m;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Raise sw_start at this negedge and measure cycles until ana_req.
    task automatic sw_measure(output int dly);
        int t0;
        sw_start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        sw_start = 1'b0;
        dly = -1;
        for (int k = 0; k < 3000; k++) begin
            if (ana_req) begin
                dly = cyc - t0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic pulse_sw();
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 3000 && !data_ready; k++) @(negedge clk);
    endtask

    task automatic wait_req_low();
        for (int k = 0; k < 3000 && ana_req; k++) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        result_rd = 1'b1;
        @(negedge clk);
        result_rd = 1'b0;
    endtask

    // Count request rises over n cycles.
    task automatic watch(int n, output int rises);
        int r0;
        r0 = req_rises;
        repeat (n) @(negedge clk);
        rises = req_rises - r0;
    endtask

    task automatic t_reset_state();
        mode_word = mk_mode(1, 1, 2);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11", "result in reset", int'(result), 0);
        check("R11", "data_ready in reset", int'(data_ready), 0);
        check("R11", "overrun in reset", int'(overrun), 0);
        check("R11", "ana_req in reset", int'(ana_req), 0);
        rst_n = 1'b1;
    endtask

    // Start sampled on the last warm-up edge (64) is ignored.
    task automatic t_warm_edge();
        int d, r;
        do_reset(mk_mode(1, 1, 2));
        repeat (63) @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        watch(40, r);
        check("R3", "start at warm-up end ignored", r, 0);
        @(negedge clk);
        sw_measure(d);
        check("R2", "latency PRE=1 SH=2", d, 12);
        wait_ready();
        check("R7", "result after completion", int'(result), sent_val);
        check("R7", "data_ready after completion", int'(data_ready), 1);
        check("R7", "ana_req low after done", int'(ana_req), 0);
        do_read();
    endtask

    // Start sampled one cycle after warm-up is accepted.
    task automatic t_warm_accept();
        int d;
        do_reset(mk_mode(1, 1, 2));
        repeat (64) @(negedge clk);
        sw_measure(d);
        check("R3", "start just after warm-up accepted", d, 12);
        wait_ready();
        do_read();
    endtask

    task automatic lat_case(logic [31:0] m, int exp, string what);
        int d;
        mode_word = m;
        @(negedge clk);
        sw_measure(d);
        check("R2", what, d, exp);
        wait_ready();
        check("R4", "software start delivers result", int'(result), sent_val);
        do_read();
    endtask

    task automatic t_prescale();
        lat_case(mk_mode(0, 0, 0), 2, "latency PRE=0 SH=0");
        lat_case(mk_mode(3, 0, 5), 48, "latency PRE=3 SH=5");
        lat_case(mk_mode(4, 0, 1) | 32'hF0E0_C0FF, 20, "R1 latency PRE=4 SH=1 with spare bits set");
        mode_word = mk_mode(1, 1, 2);
    endtask

    task automatic t_busy();
        int r0, r;
        r0 = req_rises;
        pulse_sw();
        repeat (3) @(negedge clk);
        pulse_sw();
        for (int k = 0; k < 100 && !ana_req; k++) @(negedge clk);
        pulse_sw();
        wait_ready();
        watch(60, r);
        check("R6", "starts while busy ignored", req_rises - r0, 1);
        do_read();
    endtask

    task automatic t_hw();
        int r, d, t0;
        hw_trig_en = 1'b1;
        trig_sel = 1'b1;
        repeat (5) @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        watch(60, r);
        check("R5", "sw_start ignored in hw mode", r, 0);
        trig_in[0] = 1'b1;
        watch(60, r);
        check("R5", "unselected trigger ignored", r, 0);
        trig_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        r = req_rises;
        trig_in[1] = 1'b1;
        t0 = cyc + 1;
        d = -1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (ana_req) begin
                d = cyc - t0;
                break;
            end
        end
        check("R5", "trigger latency", d, 14);
        wait_ready();
        check("R5", "trigger result", int'(result), sent_val);
        do_read();
        repeat (60) @(negedge clk);
        check("R5", "held trigger starts one conversion", req_rises - r, 1);
        trig_in[1] = 1'b0;
        repeat (5) @(negedge clk);
        trig_in[1] = 1'b1;
        wait_ready();
        check("R5", "second edge starts again", req_rises - r, 2);
        do_read();
        trig_in[1] = 1'b0;
        hw_trig_en = 1'b0;
        repeat (5) @(negedge clk);
        trig_in[1] = 1'b1;
        watch(60, r);
        check("R4", "trigger ignored in software mode", r, 0);
        trig_in[1] = 1'b0;
        trig_sel = 1'b0;
    endtask

    task automatic t_overrun();
        int first;
        pulse_sw();
        wait_ready();
        first = sent_val;
        check("R9", "no overrun after one result", int'(overrun), 0);
        check("R9", "first result", int'(result), first);
        pulse_sw();
        for (int k = 0; k < 100 && !ana_req; k++) @(negedge clk);
        wait_req_low();
        check("R9", "overrun set", int'(overrun), 1);
        check("R9", "newer result kept", int'(result), sent_val);
        check("R9", "data_ready still set", int'(data_ready), 1);
        first = sent_val;
        do_read();
        check("R8", "read clears data_ready", int'(data_ready), 0);
        check("R8", "read clears overrun", int'(overrun), 0);
        check("R8", "read keeps result", int'(result), first);
    endtask

    task automatic t_soft_reset();
        int r, d;
        pulse_sw();
        wait_ready();
        pulse_sw();
        for (int k = 0; k < 100 && !ana_req; k++) @(negedge clk);
        repeat (2) @(negedge clk);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        check("R10", "ana_req aborted", int'(ana_req), 0);
        check("R10", "data_ready cleared", int'(data_ready), 0);
        check("R10", "overrun cleared", int'(overrun), 0);
        check("R10", "result cleared", int'(result), 0);
        pulse_sw();
        watch(40, r);
        check("R10", "start ignored during new warm-up", r, 0);
        repeat (40) @(negedge clk);
        sw_measure(d);
        check("R10", "latency after soft reset", d, 12);
        wait_ready();
        check("R10", "result after soft reset", int'(result), sent_val);
        do_read();
    endtask

    initial begin
        t_reset_state();
        t_warm_edge();
        t_warm_accept();
        t_prescale();
        t_busy();
        t_hw();
        t_overrun();
        t_soft_reset();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule